// File: doc/BRIEF.md
# Receive Word Pattern Detector

This block watches the stream of words coming out of a serial-peripheral receive shifter and flags when a programmed pattern turns up inside a frame. Two compare values, `match_a` and `match_b`, are set up alongside a 3-bit `mode` input. The mode chooses where the pattern may appear: only at the start of the frame, or anywhere in it. It also chooses what the pattern is:

- one word equal to either value,
- a word equal to `match_a` followed directly by one equal to `match_b`, or
- a masked compare in which `match_b` acts as the bit mask.

A frame begins with `frame_start`. Each received word arrives with a one-cycle `word_valid` strobe. When a pattern completes, `hit` pulses high for one cycle, and that pulse is meant to set a status flag. After a hit, the detector stays quiet until the next frame begins. Only the low `word_len_m1+1` bits of the word and of both compare values take part in any compare.

Top module: `rx_word_match`

## Requirements
- R1: With `mode` 0 or 1, `hit` never rises, whatever words arrive.
- R2: With `mode` 2, a hit is reported when the first word of a frame equals `match_a` or `match_b`. Later words never hit.
- R3: With `mode` 3, a hit is reported when any word of the frame equals `match_a` or `match_b`.
- R4: With `mode` 4, a hit is reported on the second word of a frame when the first word equals `match_a` and the second equals `match_b`.
- R5: With `mode` 5, a hit is reported when a word equals `match_b` and the word received just before it, in the same frame, equalled `match_a`.
- R6: With `mode` 6, a hit is reported when (first word AND `match_b`) equals (`match_a` AND `match_b`).
- R7: With `mode` 7, the masked compare of R6 is applied to every word of the frame.
- R8: `hit` is high for exactly the one cycle after the `word_valid` strobe that completes the pattern. Idle cycles between words do not break a sequence.
- R9: `hit` fires at most once per frame, and is re-armed by the next `frame_start`.
- R10: `frame_start` clears the sequence history. A word strobed in the same cycle as `frame_start` is the first word of the new frame.
- R11: Only bits `word_len_m1:0` of the word and of both compare values are compared. Higher bits are ignored.
- R12: After reset, `hit` is low, the sequence history is empty, and the next word counts as a first word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Starts a new frame; clears history and re-arms |
| word_valid | input | 1 | Strobe: `word_data` holds a received word |
| word_data | input | WIDTH | Received word |
| word_len_m1 | input | clog2(WIDTH) | Current word size in bits minus one |
| mode | input | 3 | Pattern select, 0..7 as in R1–R7 |
| match_a | input | WIDTH | First compare value |
| match_b | input | WIDTH | Second compare value, or the mask in modes 6 and 7 |
| hit | output | 1 | One-cycle pattern-found pulse |

## Verification
A table of three-word frames is run through every mode, with the matching word placed first, in the middle, or last. Placing it this way separates the first-word-only modes from the any-word modes. Sequence frames test:

- the two values in the wrong order,
- the two values separated by another word,
- a repeated `match_a` followed by `match_b`.

These separate true adjacency from mere presence. Directed cases then cover:

- word-size truncation, with high bits that differ,
- a `frame_start` landing between the two halves of a sequence,
- idle gaps inside a sequence,
- a second matching word in the same frame, which shows that only one pulse is produced.

// File: rtl/rx_word_match.sv
module rx_word_match #(
  parameter int WIDTH = 32,
  localparam int LW = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic             word_valid,
  input  logic [WIDTH-1:0] word_data,
  input  logic [LW-1:0]    word_len_m1,
  input  logic [2:0]       mode,
  input  logic [WIDTH-1:0] match_a,
  input  logic [WIDTH-1:0] match_b,
  output logic             hit
);

  localparam logic [LW-1:0] TOP = LW'(WIDTH - 1);
  localparam logic [2:0] M_FIRST_EQ  = 3'd2;
  localparam logic [2:0] M_ANY_EQ    = 3'd3;
  localparam logic [2:0] M_FIRST_SEQ = 3'd4;
  localparam logic [2:0] M_ANY_SEQ   = 3'd5;
  localparam logic [2:0] M_FIRST_MSK = 3'd6;
  localparam logic [2:0] M_ANY_MSK   = 3'd7;

  logic is_first, is_second, prev_a, done;

  logic [WIDTH-1:0] mask, w, a, b;
  assign mask = {WIDTH{1'b1}} >> (TOP - word_len_m1);
  assign w = word_data & mask;
  assign a = match_a & mask;
  assign b = match_b & mask;

  logic eq_a, eq_b, eq_m;
  assign eq_a = (w == a);
  assign eq_b = (w == b);
  assign eq_m = ((w & b) == (a & b));

  logic first_now, second_now, prev_now, done_now;
  assign first_now  = frame_start | is_first;
  assign second_now = ~frame_start & is_second;
  assign prev_now   = ~frame_start & prev_a;
  assign done_now   = ~frame_start & done;

  logic pattern;
  always_comb begin
    case (mode)
      M_FIRST_EQ:  pattern = first_now & (eq_a | eq_b);
      M_ANY_EQ:    pattern = eq_a | eq_b;
      M_FIRST_SEQ: pattern = second_now & prev_now & eq_b;
      M_ANY_SEQ:   pattern = prev_now & eq_b;
      M_FIRST_MSK: pattern = first_now & eq_m;
      M_ANY_MSK:   pattern = eq_m;
      default:     pattern = 1'b0;
    endcase
  end

  logic fire;
  assign fire = word_valid & pattern & ~done_now;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      is_first  <= 1'b1;
      is_second <= 1'b0;
      prev_a    <= 1'b0;
      done      <= 1'b0;
      hit       <= 1'b0;
    end else begin
      hit  <= fire;
      done <= done_now | fire;
      if (word_valid) begin
        is_first  <= 1'b0;
        is_second <= first_now;
        prev_a    <= eq_a & ((mode != M_FIRST_SEQ) | first_now);
      end else begin
        is_first  <= first_now;
        is_second <= second_now;
        prev_a    <= prev_now;
      end
    end
  end

endmodule

// File: rtl/rx_word_match_chk.sv
module rx_word_match_chk #(
  parameter int WIDTH = 32,
  localparam int LW = $clog2(WIDTH)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frame_start,
  input logic             word_valid,
  input logic [WIDTH-1:0] word_data,
  input logic [LW-1:0]    word_len_m1,
  input logic [2:0]       mode,
  input logic [WIDTH-1:0] match_a,
  input logic [WIDTH-1:0] match_b,
  input logic             hit
);

  logic [WIDTH-1:0] msk;
  assign msk = {WIDTH{1'b1}} >> (LW'(WIDTH - 1) - word_len_m1);

  logic seen;
  always_ff @(posedge clk) begin
    if (!rst_n) seen <= 1'b0;
    else if (frame_start) seen <= 1'b0;
    else if (hit) seen <= 1'b1;
  end

  a_r1_off_modes_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> $past(mode) > 3'd1);

  a_r8_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> $past(word_valid));

  a_r3_any_value_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && $past(mode) == 3'd3) |->
      ($past(word_data & msk) == $past(match_a & msk)) ||
      ($past(word_data & msk) == $past(match_b & msk)));

  a_r7_masked_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && $past(mode) >= 3'd6) |->
      ($past(word_data & msk & match_b) == $past(match_a & msk & match_b)));

  a_r5_seq_ends_on_b: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && ($past(mode) == 3'd4 || $past(mode) == 3'd5)) |->
      ($past(word_data & msk) == $past(match_b & msk)));

  a_r9_once_per_frame: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> !seen);

endmodule

bind rx_word_match rx_word_match_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/tb_rx_word_match.sv
module tb_rx_word_match;
  localparam int W = 32;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, frame_start, word_valid, hit;
  logic [W-1:0] word_data, match_a, match_b;
  logic [4:0] word_len_m1;
  logic [2:0] mode;

  rx_word_match #(.WIDTH(W)) dut (.*);

  int n_chk = 0, n_bad = 0;

  task automatic check(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: hit=%0b expected %0b", tag, act, exp);
    end
  endtask

  typedef struct packed {
    logic [2:0]  md;
    logic [31:0] ma, mb, w0, w1, w2;
    logic [1:0]  at;
  } vec_t;

  localparam vec_t TBL [15] = '{
    '{3'd0, 32'hA5, 32'h3C, 32'hA5, 32'h3C, 32'hA5, 2'd0},
    '{3'd1, 32'hA5, 32'h3C, 32'hA5, 32'h3C, 32'hA5, 2'd0},
    '{3'd2, 32'hA5, 32'h3C, 32'h3C, 32'h00, 32'h00, 2'd1},
    '{3'd2, 32'hA5, 32'h3C, 32'h00, 32'hA5, 32'h00, 2'd0},
    '{3'd3, 32'hA5, 32'h3C, 32'h00, 32'h11, 32'h3C, 2'd3},
    '{3'd3, 32'hA5, 32'h3C, 32'hA5, 32'h3C, 32'hA5, 2'd1},
    '{3'd4, 32'hA5, 32'h3C, 32'hA5, 32'h3C, 32'h00, 2'd2},
    '{3'd4, 32'hA5, 32'h3C, 32'h00, 32'hA5, 32'h3C, 2'd0},
    '{3'd4, 32'hA5, 32'h3C, 32'h3C, 32'hA5, 32'h3C, 2'd0},
    '{3'd5, 32'hA5, 32'h3C, 32'h00, 32'hA5, 32'h3C, 2'd3},
    '{3'd5, 32'hA5, 32'h3C, 32'hA5, 32'h00, 32'h3C, 2'd0},
    '{3'd5, 32'hA5, 32'h3C, 32'hA5, 32'hA5, 32'h3C, 2'd3},
    '{3'd6, 32'h12, 32'hF0, 32'h1F, 32'h00, 32'h00, 2'd1},
    '{3'd6, 32'h12, 32'hF0, 32'h00, 32'h1F, 32'h00, 2'd0},
    '{3'd7, 32'h12, 32'hF0, 32'h00, 32'h55, 32'h1A, 2'd3}
  };

  task automatic idle();
    frame_start = 0; word_valid = 0;
  endtask

  // drive one word at a negedge, then check hit one negedge later
  task automatic send(input logic fs, input logic [W-1:0] d, input logic exp, input string tag);
    frame_start = fs; word_valid = 1; word_data = d;
    @(negedge clk);
    idle();
    check(hit, exp, tag);
  endtask

  function automatic string mtag(input logic [2:0] m);
    case (m)
      3'd0, 3'd1: return "R1";
      3'd2: return "R2";
      3'd3: return "R3";
      3'd4: return "R4";
      3'd5: return "R5";
      3'd6: return "R6";
      default: return "R7";
    endcase
  endfunction

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: hit=%0b expected completion", hit);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 0; idle(); word_data = 0; word_len_m1 = 5'd31;
    mode = 0; match_a = 0; match_b = 0;
    repeat (3) @(negedge clk);
    check(hit, 1'b0, "R12 reset");
    rst_n = 1;
    @(negedge clk);
    check(hit, 1'b0, "R12 after reset");

    // R8 pulse timing is checked through every table row
    foreach (TBL[i]) begin
      mode = TBL[i].md; match_a = TBL[i].ma; match_b = TBL[i].mb;
      send(1'b1, TBL[i].w0, TBL[i].at == 2'd1, {mtag(TBL[i].md), " word0"});
      send(1'b0, TBL[i].w1, TBL[i].at == 2'd2, {mtag(TBL[i].md), " word1"});
      send(1'b0, TBL[i].w2, TBL[i].at == 2'd3, {mtag(TBL[i].md), " word2"});
      @(negedge clk);
      check(hit, 1'b0, "R8 single-cycle pulse");
    end

    // R11: upper bits ignored under a short word size
    mode = 3'd2; match_a = 32'h1A5; match_b = 32'h0; word_len_m1 = 5'd7;
    send(1'b1, 32'hFF00A5, 1'b1, "R11 short word matches");
    word_len_m1 = 5'd31; match_a = 32'hA5;
    send(1'b1, 32'hFF00A5, 1'b0, "R11 full width differs");

    // R10: frame_start between the two halves breaks the sequence
    mode = 3'd5; match_a = 32'hA5; match_b = 32'h3C;
    send(1'b1, 32'hA5, 1'b0, "R10 first half");
    frame_start = 1; @(negedge clk); idle();
    send(1'b0, 32'h3C, 1'b0, "R10 history cleared");

    // R8: idle gaps keep a sequence
    mode = 3'd4;
    send(1'b1, 32'hA5, 1'b0, "R8 gap seq first");
    repeat (3) @(negedge clk);
    send(1'b0, 32'h3C, 1'b1, "R8 gap seq second");

    // R9: one pulse per frame, re-armed on new frame
    mode = 3'd3;
    send(1'b1, 32'h3C, 1'b1, "R9 first hit");
    send(1'b0, 32'hA5, 1'b0, "R9 suppressed in frame");
    send(1'b1, 32'hA5, 1'b1, "R9 re-armed next frame");

    // R12: reset mid-sequence clears history
    mode = 3'd5;
    send(1'b1, 32'hA5, 1'b0, "R12 seq start");
    rst_n = 0; @(negedge clk); rst_n = 1;
    send(1'b0, 32'h3C, 1'b0, "R12 history cleared");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule